// File: doc/BRIEF.md
# Triggered Logic Analyzer Capture Core

This block is an on-chip capture engine. It records a window of probe samples into internal memory around a trigger event. Each cycle's sample is the concatenation `{probe_bit_i, probe_bus_i}`. Before arming, software-side logic sets the trigger condition, the window length N and the trigger position P. Arming starts the capture. The core then writes one sample per clock into a ring of N slots and keeps pre-trigger history. When the trigger fires, it gathers the remaining post-trigger samples and reports completion. After that, the window can be read back by address, oldest sample first.

The controller is an enumerated state machine with five states:

- **IDLE** (status `00`): not capturing.
- **PREFILL** (status `01`): armed, the first P-1 history samples are still being gathered.
- **WAIT** (status `10`): history is full, watching for the trigger.
- **POST** (status `10`): collecting the N-P samples after the trigger.
- **DONE** (status `11`): capture complete, readout valid.

The transitions are:

- *start*: IDLE/DONE to PREFILL or WAIT, on an arm or a force.
- *filled*: PREFILL to WAIT, once P-1 samples are in.
- *fire*: PREFILL/WAIT to POST, or straight to DONE when N-P is zero.
- *drained*: POST to DONE.
- *abort*: any armed state to IDLE, on a disarm.

P counts from 1. A position of P puts the trigger sample at read address P-1. There are P-1 samples before it and N-P after it. With N=1024, a position of 513 places the trigger at index 512, midway through the window. A position of 12 gives 11 samples before and 1012 after.

Top module: `trig_capture_core`

## Requirements
- R1: After reset, status_o is `00` (IDLE) and valid_cnt_o is 0.
- R2: An arm (or force) in IDLE or DONE latches the window and position and starts a capture. The window length N is win_len_i, with 0 or any value above DEPTH meaning DEPTH. The position P is trig_pos_i, with 0 meaning 1 and values above N meaning N. Status becomes `01` if P>1, otherwise `10`. Changes to win_len_i and trig_pos_i while armed do not affect the capture.
- R3: In PREFILL, after P-1 samples have been stored, status becomes `10`. It stays `10` until a trigger or a disarm, and never returns to `01` from `10`.
- R4: The single-bit trigger modes are selected by trig_mode_i: 0 rising edge, 1 falling edge, 2 level high, 3 level low. Edges are judged against the probe bit registered on the previous clock.
- R5: trig_mode_i = 4 fires when probe_bus_i equals cmp_val_i (e.g. 67 = 0x43). Modes 5 to 7 never fire on their own.
- R6: force_i acts as a trigger on the current sample when armed. In IDLE or DONE it starts a capture and triggers on the first stored sample.
- R7: After the trigger sample, exactly N-P more samples are stored, then status becomes `11`. It holds there, with a stable valid_cnt_o, until the next arm or force.
- R8: Readout: rd_data_o returns, one clock after rd_addr_i is applied, the sample at window index rd_addr_i. Index 0 is the oldest, the trigger sample is at index P-1, and bit DATA_W is the probe bit.
- R9: A trigger during PREFILL is accepted. In DONE, valid_cnt_o = (pre-trigger samples actually stored) + 1 + (N-P). Indices below N - valid_cnt_o are not valid; valid_cnt_o is 0 outside DONE.
- R10: A disarm in PREFILL, WAIT or POST returns status to `00` on the next clock, taking priority over a trigger in the same cycle.
- R11: Trigger conditions have no effect in IDLE or DONE.
- R12: With N=1024 and P=12, the trigger sample is read at index 11, with 11 valid samples before it and 1012 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_bit_i | input | 1 | Single-bit probe |
| probe_bus_i | input | DATA_W | Bus probe |
| arm_i | input | 1 | Start a capture |
| disarm_i | input | 1 | Abort a capture |
| force_i | input | 1 | Trigger immediately |
| trig_mode_i | input | 3 | Trigger condition select |
| cmp_val_i | input | DATA_W | Bus compare value |
| win_len_i | input | AW+1 | Window length N |
| trig_pos_i | input | AW+1 | Trigger position P (1-based) |
| rd_addr_i | input | AW | Readout window index |
| status_o | output | 2 | 00 idle, 01 prefill, 10 waiting/collecting, 11 done |
| valid_cnt_o | output | AW+1 | Valid samples in the finished window |
| rd_data_o | output | DATA_W+1 | Read sample {bit, bus} |

## Verification
The hardest situation to reach is a trigger that lands during PREFILL. In that case the window has unfilled leading slots, and the ring is only partly written when the trigger pointer is latched. The bench reaches it in two ways: by raising a level-high probe a few cycles after arming with a large trigger position, and by a force issued from IDLE, which triggers on the very first stored sample. The bus probe free-runs as a counter, so every stored sample is distinct. The behavioural reference keeps a queue of everything stored since arming, so each readout index is checked against the exact sample the remap should select.

// File: rtl/trig_cap_pkg.sv
package trig_cap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREFILL,
        ST_WAIT,
        ST_POST,
        ST_DONE
    } cap_state_e;

    localparam logic [2:0] MODE_RISE = 3'd0;
    localparam logic [2:0] MODE_FALL = 3'd1;
    localparam logic [2:0] MODE_HIGH = 3'd2;
    localparam logic [2:0] MODE_LOW  = 3'd3;
    localparam logic [2:0] MODE_BUSEQ = 3'd4;

    localparam logic [1:0] STAT_IDLE = 2'b00;
    localparam logic [1:0] STAT_FILL = 2'b01;
    localparam logic [1:0] STAT_WAIT = 2'b10;
    localparam logic [1:0] STAT_DONE = 2'b11;

endpackage

// File: rtl/trig_detect.sv
module trig_detect
    import trig_cap_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              probe_bit,
    input  logic [DATA_W-1:0] probe_bus,
    input  logic [2:0]        mode,
    input  logic [DATA_W-1:0] cmp_val,
    output logic              hit
);

    logic prev_bit;

    // one-cycle history of the bit probe for edge conditions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_bit <= 1'b0;
        end else begin
            prev_bit <= probe_bit;
        end
    end

    always_comb begin
        hit = 1'b0;
        unique case (mode)
            MODE_RISE:  hit = !prev_bit && probe_bit;
            MODE_FALL:  hit = prev_bit && !probe_bit;
            MODE_HIGH:  hit = probe_bit;
            MODE_LOW:   hit = !probe_bit;
            MODE_BUSEQ: hit = (probe_bus == cmp_val);
            default:    hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
    import trig_cap_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          disarm,
    input  logic          force_trig,
    input  logic          hit,
    input  logic [AW:0]   win_len,
    input  logic [AW:0]   trig_pos,
    output logic          we,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] tptr,
    output logic [AW:0]   cfg_len,
    output logic [AW:0]   cfg_pre,
    output logic [1:0]    status,
    output logic [AW:0]   valid_cnt
);

    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
    localparam logic [AW:0] ONE_V   = (AW+1)'(1);
    localparam logic [AW:0] ZERO_V  = '0;

    cap_state_e  state, state_nx;
    logic [AW:0] cfg_post;
    logic [AW:0] pre_cnt;
    logic [AW:0] pre_have;
    logic [AW:0] post_rem;
    logic        force_pend;

    // clamped configuration, sampled only at start
    logic [AW:0] len_c, pos_c, pre_c, post_c;
    logic        start, fire, armed, trig_ev;

    always_comb begin
        len_c = ((win_len == ZERO_V) || (win_len > DEPTH_V)) ? DEPTH_V : win_len;
        if (trig_pos == ZERO_V) begin
            pos_c = ONE_V;
        end else if (trig_pos > len_c) begin
            pos_c = len_c;
        end else begin
            pos_c = trig_pos;
        end
        pre_c  = pos_c - ONE_V;
        post_c = len_c - pos_c;
    end

    assign start   = arm || force_trig;
    assign fire    = hit || force_trig || force_pend;
    assign armed   = (state == ST_PREFILL) || (state == ST_WAIT) || (state == ST_POST);
    assign trig_ev = ((state == ST_PREFILL) || (state == ST_WAIT)) && !disarm && fire;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_nx = (pre_c == ZERO_V) ? ST_WAIT : ST_PREFILL;
                end
            end
            ST_PREFILL: begin
                if (disarm) begin
                    state_nx = ST_IDLE;
                end else if (fire) begin
                    state_nx = (cfg_post == ZERO_V) ? ST_DONE : ST_POST;
                end else if ((pre_cnt + ONE_V) == cfg_pre) begin
                    state_nx = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (disarm) begin
                    state_nx = ST_IDLE;
                end else if (fire) begin
                    state_nx = (cfg_post == ZERO_V) ? ST_DONE : ST_POST;
                end
            end
            ST_POST: begin
                if (disarm) begin
                    state_nx = ST_IDLE;
                end else if (post_rem == ONE_V) begin
                    state_nx = ST_DONE;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // capture datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_len    <= DEPTH_V;
            cfg_pre    <= ZERO_V;
            cfg_post   <= ZERO_V;
            pre_cnt    <= ZERO_V;
            pre_have   <= ZERO_V;
            post_rem   <= ZERO_V;
            wptr       <= '0;
            tptr       <= '0;
            force_pend <= 1'b0;
        end else begin
            if (((state == ST_IDLE) || (state == ST_DONE)) && start) begin
                cfg_len    <= len_c;
                cfg_pre    <= pre_c;
                cfg_post   <= post_c;
                pre_cnt    <= ZERO_V;
                wptr       <= '0;
                force_pend <= force_trig;
            end
            if (armed) begin
                wptr <= ({1'b0, wptr} == (cfg_len - ONE_V)) ? '0 : wptr + 1'b1;
            end
            if ((state == ST_PREFILL) && !disarm && !fire) begin
                pre_cnt <= pre_cnt + ONE_V;
            end
            if (trig_ev) begin
                tptr       <= wptr;
                pre_have   <= (state == ST_PREFILL) ? pre_cnt : cfg_pre;
                post_rem   <= cfg_post;
                force_pend <= 1'b0;
            end
            if ((state == ST_POST) && !disarm) begin
                post_rem <= post_rem - ONE_V;
            end
            if (armed && disarm) begin
                force_pend <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        we        = armed;
        valid_cnt = ZERO_V;
        status    = STAT_IDLE;
        unique case (state)
            ST_IDLE:    status = STAT_IDLE;
            ST_PREFILL: status = STAT_FILL;
            ST_WAIT:    status = STAT_WAIT;
            ST_POST:    status = STAT_WAIT;
            ST_DONE: begin
                status    = STAT_DONE;
                valid_cnt = pre_have + ONE_V + cfg_post;
            end
        endcase
    end

endmodule

// File: rtl/rd_remap.sv
module rd_remap #(
    parameter int AW = 10
) (
    input  logic [AW-1:0] tptr,
    input  logic [AW-1:0] rd_addr,
    input  logic [AW:0]   cfg_len,
    input  logic [AW:0]   cfg_pre,
    output logic [AW-1:0] phys
);

    localparam int SW = AW + 2;

    logic [SW-1:0] len_w, sum0, sum1, sum2;

    // oldest slot sits cfg_pre slots behind the trigger, modulo the window
    always_comb begin
        len_w = SW'(cfg_len);
        sum0  = SW'(tptr) + SW'(rd_addr) + (len_w - SW'(cfg_pre));
        sum1  = (sum0 >= len_w) ? (sum0 - len_w) : sum0;
        sum2  = (sum1 >= len_w) ? (sum1 - len_w) : sum1;
        phys  = sum2[AW-1:0];
    end

endmodule

// File: rtl/cap_ram.sv
module cap_ram #(
    parameter int W     = 9,
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/trig_capture_core.sv
module trig_capture_core
    import trig_cap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH),
    localparam int SMP_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              probe_bit_i,
    input  logic [DATA_W-1:0] probe_bus_i,
    input  logic              arm_i,
    input  logic              disarm_i,
    input  logic              force_i,
    input  logic [2:0]        trig_mode_i,
    input  logic [DATA_W-1:0] cmp_val_i,
    input  logic [AW:0]       win_len_i,
    input  logic [AW:0]       trig_pos_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [1:0]        status_o,
    output logic [AW:0]       valid_cnt_o,
    output logic [SMP_W-1:0]  rd_data_o
);

    logic          hit_w;
    logic          we_w;
    logic [AW-1:0] wptr_w, tptr_w, phys_w;
    logic [AW:0]   cfg_len_w, cfg_pre_w;

    trig_detect #(.DATA_W(DATA_W)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .probe_bit (probe_bit_i),
        .probe_bus (probe_bus_i),
        .mode      (trig_mode_i),
        .cmp_val   (cmp_val_i),
        .hit       (hit_w)
    );

    cap_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm_i),
        .disarm     (disarm_i),
        .force_trig (force_i),
        .hit        (hit_w),
        .win_len    (win_len_i),
        .trig_pos   (trig_pos_i),
        .we         (we_w),
        .wptr       (wptr_w),
        .tptr       (tptr_w),
        .cfg_len    (cfg_len_w),
        .cfg_pre    (cfg_pre_w),
        .status     (status_o),
        .valid_cnt  (valid_cnt_o)
    );

    rd_remap #(.AW(AW)) u_remap (
        .tptr    (tptr_w),
        .rd_addr (rd_addr_i),
        .cfg_len (cfg_len_w),
        .cfg_pre (cfg_pre_w),
        .phys    (phys_w)
    );

    cap_ram #(.W(SMP_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (we_w),
        .waddr (wptr_w),
        .wdata ({probe_bit_i, probe_bus_i}),
        .raddr (phys_w),
        .rdata (rd_data_o)
    );

endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk #(
    parameter int AW = 10
) (
    input logic        clk,
    input logic        rst_n,
    input logic        arm_i,
    input logic        disarm_i,
    input logic        force_i,
    input logic [1:0]  status_o,
    input logic [AW:0] valid_cnt_o,
    input logic [AW:0] cfg_len
);

    // R10
    disarm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disarm_i && (status_o == 2'b01 || status_o == 2'b10)) |=> (status_o == 2'b00));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'b00 && !arm_i && !force_i) |=> (status_o == 2'b00));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'b11 && !arm_i && !force_i) |=> (status_o == 2'b11 && $stable(valid_cnt_o)));

    // R9
    valid_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'b11) |-> (valid_cnt_o != '0 && valid_cnt_o <= cfg_len));

    // R3
    wait_noback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'b10) |=> (status_o != 2'b01));

    // R2
    arm_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o == 2'b00 || status_o == 2'b11) && (arm_i || force_i))
        |=> (status_o == 2'b01 || status_o == 2'b10));

endmodule

bind trig_capture_core trig_capture_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_i       (arm_i),
    .disarm_i    (disarm_i),
    .force_i     (force_i),
    .status_o    (status_o),
    .valid_cnt_o (valid_cnt_o),
    .cfg_len     (cfg_len_w)
);

// File: tb/trig_capture_core_bench.sv
`timescale 1ns/1ps
module trig_capture_core_bench;

    localparam int DW    = 8;
    localparam int DEPTH = 1024;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          probe_bit = 1'b0;
    logic [DW-1:0] probe_bus = '0;
    logic          arm = 1'b0, disarm = 1'b0, frc = 1'b0;
    logic [2:0]    mode = 3'd0;
    logic [DW-1:0] cmp = '0;
    logic [AW:0]   wlen = '0, tpos = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [1:0]    status;
    logic [AW:0]   valid_cnt;
    logic [DW:0]   rd_data;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    trig_capture_core #(.DATA_W(DW), .DEPTH(DEPTH)) u_trig_capture_core (
        .clk(clk), .rst_n(rst_n), .probe_bit_i(probe_bit), .probe_bus_i(probe_bus),
        .arm_i(arm), .disarm_i(disarm), .force_i(frc), .trig_mode_i(mode),
        .cmp_val_i(cmp), .win_len_i(wlen), .trig_pos_i(tpos), .rd_addr_i(rd_addr),
        .status_o(status), .valid_cnt_o(valid_cnt), .rd_data_o(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int m_st = 0;  // 0 idle 1 prefill 2 wait 3 post 4 done
    int m_len = DEPTH, m_pre = 0, m_post = 0, m_tidx = 0, m_seen = 0, m_rem = 0;
    bit m_fp = 0;
    logic m_prev = 1'b0;
    logic [DW:0] hist[$];

    function automatic bit m_hit();
        case (mode)
            3'd0: return !m_prev && probe_bit;
            3'd1: return m_prev && !probe_bit;
            3'd2: return probe_bit;
            3'd3: return !probe_bit;
            3'd4: return probe_bus == cmp;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_prev = 1'b0; m_fp = 0;
        end else begin
            bit h;
            int l, p;
            h = m_hit();
            if (m_st == 0 || m_st == 4) begin
                if (arm || frc) begin
                    l = int'(wlen);
                    if (l == 0 || l > DEPTH) l = DEPTH;
                    p = int'(tpos);
                    if (p == 0) p = 1;
                    if (p > l) p = l;
                    m_len = l; m_pre = p - 1; m_post = l - p;
                    hist.delete();
                    m_fp = frc;
                    m_st = (m_pre == 0) ? 2 : 1;
                end
            end else begin
                hist.push_back({probe_bit, probe_bus});
                if (m_st == 2 && hist.size() > m_pre + 1) void'(hist.pop_front());
                if (disarm) begin
                    m_st = 0; m_fp = 0;
                end else if ((m_st == 1 || m_st == 2) && (h || frc || m_fp)) begin
                    m_fp = 0;
                    m_tidx = hist.size() - 1;
                    m_seen = (m_tidx < m_pre) ? m_tidx : m_pre;
                    m_rem = m_post;
                    m_st = (m_post == 0) ? 4 : 3;
                end else if (m_st == 1 && hist.size() == m_pre) begin
                    m_st = 2;
                end else if (m_st == 3) begin
                    m_rem--;
                    if (m_rem == 0) m_st = 4;
                end
            end
            m_prev = probe_bit;
        end
    end

    function automatic int exp_status();
        case (m_st)
            0: return 0;
            1: return 1;
            4: return 3;
            default: return 2;
        endcase
    endfunction

    function automatic int exp_valid();
        return (m_st == 4) ? (m_seen + 1 + m_post) : 0;
    endfunction

    // compare against the model on every clock (R3 R7 R9 R10)
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(status) == exp_status(), "R3/R7/R10 status", status, exp_status());
            chk(int'(valid_cnt) == exp_valid(), "R9 valid_cnt", valid_cnt, exp_valid());
        end
    end

    // free-running bus probe gives every sample a distinct value
    initial forever begin
        @(negedge clk);
        probe_bus = probe_bus + 1'b1;
    end

    // ---------------- stimulus helpers ----------------
    task automatic cfg(input logic [2:0] md, input int cv, input int ln, input int ps);
        mode = md; cmp = DW'(cv); wlen = (AW+1)'(ln); tpos = (AW+1)'(ps);
    endtask

    task automatic pulse_arm();
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic wait_status(input logic [1:0] code, input int limit);
        for (int i = 0; i < limit && status != code; i++) @(negedge clk);
    endtask

    task automatic read_all(input string tag);
        int first;
        first = m_pre - m_seen;
        @(negedge clk); rd_addr = '0;
        for (int a = 0; a < m_len; a++) begin
            @(negedge clk);
            if (a >= first) chk(rd_data == hist[m_tidx - m_pre + a], tag, rd_data, hist[m_tidx - m_pre + a]);
            rd_addr = AW'(a + 1);
        end
    endtask

    task automatic read_at(input int a, output logic [DW:0] d);
        @(negedge clk); rd_addr = AW'(a);
        @(negedge clk); d = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DW:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(status == 2'b00, "R1 reset status", status, 0);
        chk(valid_cnt == '0, "R1 reset valid", valid_cnt, 0);

        // R11: level-high condition true while idle
        cfg(3'd2, 0, 16, 4);
        probe_bit = 1'b1;
        repeat (20) @(negedge clk);
        chk(status == 2'b00, "R11 idle ignores trigger", status, 0);
        probe_bit = 1'b0;

        // R4 rising edge, R8 readout
        cfg(3'd0, 0, 64, 32);
        pulse_arm();
        chk(status == 2'b01, "R2 prefill after arm", status, 1);
        wait_status(2'b10, 100);
        repeat (5) @(negedge clk);
        chk(status == 2'b10, "R3 waiting", status, 2);
        probe_bit = 1'b1;
        wait_status(2'b11, 200);
        chk(valid_cnt == 64, "R4 rise full window", valid_cnt, 64);
        read_all("R8 rise readout");
        read_at(31, d);
        chk(d[DW] == 1'b1, "R4 trigger sample bit at P-1", d[DW], 1);

        // R4 falling edge
        cfg(3'd1, 0, 16, 4);
        pulse_arm();
        repeat (10) @(negedge clk);
        probe_bit = 1'b0;
        wait_status(2'b11, 100);
        chk(status == 2'b11, "R4 fall done", status, 3);
        read_all("R4 fall readout");

        // R4 level low
        cfg(3'd3, 0, 16, 8);
        probe_bit = 1'b1;
        pulse_arm();
        repeat (12) @(negedge clk);
        probe_bit = 1'b0;
        wait_status(2'b11, 100);
        read_all("R4 low readout");

        // R5 bus equality 67
        cfg(3'd4, 67, 64, 32);
        pulse_arm();
        wait_status(2'b11, 600);
        read_at(31, d);
        chk(d[DW-1:0] == 8'd67, "R5 bus trigger at P-1", d[DW-1:0], 67);
        read_all("R5 bus readout");

        // R5 mode 5 never fires
        cfg(3'd5, 0, 16, 4);
        pulse_arm();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); probe_bit = ~probe_bit;
        end
        chk(status == 2'b10, "R5 reserved mode silent", status, 2);
        @(negedge clk); disarm = 1'b1;
        @(negedge clk); disarm = 1'b0;
        chk(status == 2'b00, "R10 disarm in wait", status, 0);

        // R6 force from idle, R9 early trigger
        cfg(3'd5, 0, 32, 16);
        @(negedge clk); frc = 1'b1;
        @(negedge clk); frc = 1'b0;
        wait_status(2'b11, 100);
        chk(valid_cnt == 17, "R6/R9 force from idle valid", valid_cnt, 17);
        read_all("R6 force readout");

        // R9 trigger during prefill
        probe_bit = 1'b0;
        cfg(3'd2, 0, 64, 40);
        pulse_arm();
        repeat (9) @(negedge clk);
        probe_bit = 1'b1;
        wait_status(2'b11, 100);
        chk(valid_cnt < 64, "R9 early trigger partial", valid_cnt, 64);
        read_all("R9 early readout");
        probe_bit = 1'b0;

        // R2 config change while armed, R6 force while armed
        cfg(3'd5, 0, 32, 8);
        pulse_arm();
        cfg(3'd5, 0, 200, 100);
        repeat (20) @(negedge clk);
        frc = 1'b1; @(negedge clk); frc = 1'b0;
        wait_status(2'b11, 100);
        chk(valid_cnt == 32, "R2 latched window", valid_cnt, 32);
        read_all("R2 latched readout");

        // R10 disarm during post, and disarm beats force
        cfg(3'd5, 0, 64, 2);
        pulse_arm();
        repeat (4) @(negedge clk);
        frc = 1'b1; @(negedge clk); frc = 1'b0;
        repeat (5) @(negedge clk);
        disarm = 1'b1; @(negedge clk); disarm = 1'b0;
        chk(status == 2'b00, "R10 disarm in post", status, 0);
        pulse_arm();
        repeat (4) @(negedge clk);
        disarm = 1'b1; frc = 1'b1; @(negedge clk);
        disarm = 1'b0; frc = 1'b0;
        chk(status == 2'b00, "R10 disarm priority", status, 0);

        // R2 clamps: position 0 -> 1, position above N -> N
        cfg(3'd5, 0, 16, 0);
        pulse_arm();
        chk(status == 2'b10, "R2 pos0 clamps to 1", status, 2);
        frc = 1'b1; @(negedge clk); frc = 1'b0;
        wait_status(2'b11, 50);
        read_all("R2 pos0 readout");
        cfg(3'd5, 0, 16, 40);
        pulse_arm();
        wait_status(2'b10, 50);
        frc = 1'b1; @(negedge clk); frc = 1'b0;
        @(negedge clk);
        chk(status == 2'b11, "R7 P=N done next cycle", status, 3);
        read_all("R2 posN readout");

        // R12 full default window, position 12
        cfg(3'd4, 8'h43, 0, 12);
        pulse_arm();
        wait_status(2'b11, 2000);
        chk(valid_cnt == 1024, "R12 full window", valid_cnt, 1024);
        read_at(11, d);
        chk(d[DW-1:0] == 8'h43, "R12 trigger at index 11", d[DW-1:0], 8'h43);
        read_at(10, d);
        chk(d[DW-1:0] == 8'h42, "R12 sample before trigger", d[DW-1:0], 8'h42);
        read_all("R12 readout");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule